// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core. There are five sources: three external pins that trigger on an edge, a timer overflow strobe, and a change on a four-bit group of input port bits. Each source has a sticky flag and an enable bit. Every source except external pin 0 also has a priority bit. Pin 0 is always high priority. The block drives a high-priority request, a low-priority request, a branch request gated by a global enable, and a wake pulse for a core that sits in a power-managed (sleep) state.

Software uses a small register port to set enables, priorities and edge polarity, and to clear or set flags. Writes take effect at the clock edge. Reads are combinational.

Pin and port inputs pass through a two-flop synchronizer before detection. A pin edge or a port change therefore shows up in its flag on the third rising clock edge after the input moves. A timer strobe shows up in its flag on the next edge.

A three-state power tracker drives the wake output:
- `PS_AWAKE`: the core runs.
- `PS_ASLEEP`: `sleep_i` is high.
- `PS_ROUSE`: the single wake cycle.

Transitions at each edge:
- Sleep request with a rising enabled flag → `PS_ROUSE`.
- Sleep request without one → `PS_ASLEEP`.
- No sleep request → `PS_AWAKE`.

These transitions apply from every state.

Top module: `prio_irq_ctrl`

Register map (`reg_addr`):
- Address 0 (main):
  - [7] global enable
  - [5] timer enable
  - [4] pin 0 enable
  - [3] port-change enable
  - [2] timer flag
  - [1] pin 0 flag
  - [0] port-change flag
- Address 1 (aux):
  - [6:4] edge select for pins 2, 1, 0 (1 = rising, 0 = falling)
  - [2] timer priority
  - [0] port-change priority
- Address 2 (ext):
  - [7] pin 2 priority
  - [6] pin 1 priority
  - [4] pin 2 enable
  - [3] pin 1 enable
  - [1] pin 2 flag
  - [0] pin 1 flag
- Address 3 reads zero.
- Bits not listed read zero.
- A priority bit of 1 means high.

## Requirements
- R1: After reset, address 0 and address 2 read 0x00 and address 1 reads 0x70. At reset all flags, enables and priorities are 0, and all edge selects are 1.
- R2: A pin whose edge-select bit is 1 sets its flag on a rising edge only. A pin whose edge-select bit is 0 sets its flag on a falling edge only.
- R3: A flag sets whether or not its enable is 1. It stays set until software writes 0 to its bit.
- R4: Pin 0 with flag and enable both 1 always drives `irq_hi`. Pins 1 and 2 take their level from address 2 bits 6 and 7.
- R5: `tmr_ovf` sets the timer flag (address 0 bit 2). Its enable is address 0 bit 5 and its priority is address 1 bit 2.
- R6: Any change on `port_in` sets the port-change flag (address 0 bit 0). A steady input does not set it again after a clear. Its enable is address 0 bit 3 and its priority is address 1 bit 0.
- R7: A source requests when its flag and its enable are both 1. `irq_hi` is the OR of high-priority requests. `irq_lo` is the OR of low-priority requests, and it is held low while `irq_hi` is high.
- R8: If a hardware set and a software write of 0 hit the same flag at the same edge, the flag ends up set.
- R9: `branch_req` is high exactly when the global enable (address 0 bit 7) is 1 and `irq_hi` or `irq_lo` is high.
- R10: `wake` is high for one cycle when an enabled flag rises while `sleep_i` is high, whatever the global enable. It stays low for a disabled source and when `sleep_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | External interrupt pins 2..0 |
| port_in | input | 4 | Watched port bits (upper nibble) |
| tmr_ovf | input | 1 | Timer overflow strobe, one cycle |
| sleep_i | input | 1 | Core is in the power-managed state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| branch_req | output | 1 | Request gated by the global enable |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The hardest case to reach is a hardware set and a software clear of the same flag at the same edge. A synchronized pin edge lands three edges after the input moves, so its timing is hard to align with a write. The bench therefore uses the timer strobe, which has no synchronizer. It drives the strobe and a write of 0 to address 0 in the same cycle. Wake pulses are counted over a window rather than sampled at one edge, so a pulse that is too long or repeats is caught as well as one that is missing.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NPIN   = 3;
    localparam int PORT_W = 4;
    localparam int NSRC   = NPIN + 2;
    localparam int S_TMR  = NPIN;
    localparam int S_CHG  = NPIN + 1;

    localparam logic [1:0] A_MAIN = 2'd0;
    localparam logic [1:0] A_AUX  = 2'd1;
    localparam logic [1:0] A_EXT  = 2'd2;

    typedef enum logic [1:0] {
        PS_AWAKE  = 2'd0,
        PS_ASLEEP = 2'd1,
        PS_ROUSE  = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign hit[i] = rise_sel[i] ? (cur[i] & ~prev_q[i])
                                    : (~cur[i] & prev_q[i]);
    end
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic         hit
);
    logic [W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= cur;
    end

    assign hit = |(cur ^ snap_q);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   ext_pin,
    input  logic [PORT_W-1:0] port_in,
    input  logic              tmr_ovf,
    input  logic              sleep_i,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_hi,
    output logic              irq_lo,
    output logic              branch_req,
    output logic              wake
);
    logic [NPIN-1:0]   pin_s, pin_hit, esel_q;
    logic [PORT_W-1:0] port_s;
    logic              chg_hit, glob_en_q;
    logic [NSRC-1:0]   flag_q, flag_d, en_q, hw_set, sw_we, sw_val, prio_eff, req;
    logic [NSRC-1:1]   prio_q;
    logic              rise_evt;
    pwr_state_t        st_q, st_d;

    irq_sync #(.W(NPIN))   u_pin_sync  (.clk(clk), .rst_n(rst_n), .d(ext_pin), .q(pin_s));
    irq_sync #(.W(PORT_W)) u_port_sync (.clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s));
    irq_edge_det #(.N(NPIN)) u_edge (.clk(clk), .rst_n(rst_n), .cur(pin_s),
                                     .rise_sel(esel_q), .hit(pin_hit));
    irq_chg_det #(.W(PORT_W)) u_chg (.clk(clk), .rst_n(rst_n), .cur(port_s), .hit(chg_hit));

    assign hw_set = {chg_hit, tmr_ovf, pin_hit};

    // software flag access decode
    always_comb begin
        sw_we  = '0;
        sw_val = '0;
        if (reg_we && reg_addr == A_MAIN) begin
            sw_we[0] = 1'b1;      sw_val[0] = reg_wdata[1];
            sw_we[S_TMR] = 1'b1;  sw_val[S_TMR] = reg_wdata[2];
            sw_we[S_CHG] = 1'b1;  sw_val[S_CHG] = reg_wdata[0];
        end
        if (reg_we && reg_addr == A_EXT) begin
            sw_we[1] = 1'b1;      sw_val[1] = reg_wdata[0];
            sw_we[2] = 1'b1;      sw_val[2] = reg_wdata[1];
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        assign flag_d[i] = hw_set[i] | (sw_we[i] ? sw_val[i] : flag_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q    <= '0;
            en_q      <= '0;
            prio_q    <= '0;
            esel_q    <= '1;
            glob_en_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (reg_we) begin
                unique case (reg_addr)
                    A_MAIN: begin
                        glob_en_q  <= reg_wdata[7];
                        en_q[S_TMR] <= reg_wdata[5];
                        en_q[0]     <= reg_wdata[4];
                        en_q[S_CHG] <= reg_wdata[3];
                    end
                    A_AUX: begin
                        esel_q        <= reg_wdata[6:4];
                        prio_q[S_TMR] <= reg_wdata[2];
                        prio_q[S_CHG] <= reg_wdata[0];
                    end
                    A_EXT: begin
                        prio_q[2] <= reg_wdata[7];
                        prio_q[1] <= reg_wdata[6];
                        en_q[2]   <= reg_wdata[4];
                        en_q[1]   <= reg_wdata[3];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_MAIN:  reg_rdata = {glob_en_q, 1'b0, en_q[S_TMR], en_q[0], en_q[S_CHG],
                                  flag_q[S_TMR], flag_q[0], flag_q[S_CHG]};
            A_AUX:   reg_rdata = {1'b0, esel_q, 1'b0, prio_q[S_TMR], 1'b0, prio_q[S_CHG]};
            A_EXT:   reg_rdata = {prio_q[2], prio_q[1], 1'b0, en_q[2], en_q[1],
                                  1'b0, flag_q[2], flag_q[1]};
            default: reg_rdata = 8'h00;
        endcase
    end

    // request combination: pin 0 fixed high
    assign prio_eff   = {prio_q, 1'b1};
    assign req        = flag_q & en_q;
    assign irq_hi     = |(req & prio_eff);
    assign irq_lo     = ~irq_hi & |(req & ~prio_eff);
    assign branch_req = glob_en_q & (irq_hi | irq_lo);

    // power tracker
    assign rise_evt = |(en_q & flag_d & ~flag_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_AWAKE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_AWAKE, PS_ASLEEP, PS_ROUSE: begin
                if (sleep_i && rise_evt) st_d = PS_ROUSE;
                else if (sleep_i)        st_d = PS_ASLEEP;
                else                     st_d = PS_AWAKE;
            end
            default: st_d = PS_AWAKE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            PS_ROUSE: wake = 1'b1;
            default:  wake = 1'b0;
        endcase
    end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_ovf,
    input logic       sleep_i,
    input logic       reg_we,
    input logic       irq_hi,
    input logic       irq_lo,
    input logic       branch_req,
    input logic       wake,
    input logic [4:0] flag_q,
    input logic [4:0] en_q
);
    // R7
    hi_lo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_hi && irq_lo));
    // R9
    branch_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_req |-> (irq_hi || irq_lo));
    // R4
    pin0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && en_q[0]) |-> irq_hi);
    // R5 R8
    tmr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> flag_q[3]);
    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
    // R10
    wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(sleep_i));
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .sleep_i(sleep_i), .reg_we(reg_we),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .branch_req(branch_req), .wake(wake),
    .flag_q(flag_q), .en_q(en_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_pin = '0;
    logic [3:0] port_in = '0;
    logic       tmr_ovf = 1'b0, sleep_i = 1'b0, reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq_hi, irq_lo, branch_req, wake;
    int         errors = 0, checks = 0, wake_cnt = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl dut (.*);

    always @(negedge clk) if (wake) wake_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 main", 2'd0, 8'h00);
        rd_chk("R1 aux", 2'd1, 8'h70);
        rd_chk("R1 ext", 2'd2, 8'h00);
        chk("R1 outs", {irq_hi, irq_lo, branch_req, wake}, 0);
    endtask

    task automatic t_edges();
        ext_pin[1] = 1'b1; settle();
        rd_chk("R2 R3 rising sets, enable off", 2'd2, 8'h01);
        settle();
        rd_chk("R3 flag stays", 2'd2, 8'h01);
        wr(2'd2, 8'h00);
        rd_chk("R3 sw clear", 2'd2, 8'h00);
        ext_pin[1] = 1'b0; settle();
        rd_chk("R2 falling ignored", 2'd2, 8'h00);
        wr(2'd1, 8'h50);
        ext_pin[1] = 1'b1; settle();
        rd_chk("R2 rising ignored in falling mode", 2'd2, 8'h00);
        ext_pin[1] = 1'b0; settle();
        rd_chk("R2 falling sets", 2'd2, 8'h01);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h70);
    endtask

    task automatic t_prio();
        wr(2'd0, 8'h10);
        ext_pin[0] = 1'b1; settle();
        rd_chk("R4 pin0 flag", 2'd0, 8'h12);
        chk("R4 pin0 high", {irq_hi, irq_lo}, 2'b10);
        chk("R9 no global", branch_req, 0);
        wr(2'd0, 8'h92);
        chk("R9 global on", branch_req, 1);
        wr(2'd2, 8'h10);
        ext_pin[2] = 1'b1; settle();
        rd_chk("R4 pin2 flag", 2'd2, 8'h12);
        chk("R7 high wins", {irq_hi, irq_lo}, 2'b10);
        wr(2'd0, 8'h90);
        chk("R7 low alone", {irq_hi, irq_lo}, 2'b01);
        chk("R9 branch on low", branch_req, 1);
        wr(2'd2, 8'h92);
        chk("R4 pin2 high via bit7", {irq_hi, irq_lo}, 2'b10);
        wr(2'd0, 8'h00); wr(2'd2, 8'h00);
        ext_pin = '0; settle();
        chk("R7 idle", {irq_hi, irq_lo, branch_req}, 0);
    endtask

    task automatic t_timer();
        pulse_tmr();
        rd_chk("R5 flag sets", 2'd0, 8'h04);
        chk("R7 disabled no req", {irq_hi, irq_lo}, 0);
        wr(2'd0, 8'h24);
        chk("R5 low prio", {irq_hi, irq_lo}, 2'b01);
        wr(2'd1, 8'h74);
        chk("R5 high prio", {irq_hi, irq_lo}, 2'b10);
        wr(2'd1, 8'h70); wr(2'd0, 8'h00);
        rd_chk("R3 cleared", 2'd0, 8'h00);
    endtask

    task automatic t_setwins();
        @(negedge clk);
        tmr_ovf = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
        @(negedge clk);
        tmr_ovf = 1'b0; reg_we = 1'b0;
        rd_chk("R8 set beats clear", 2'd0, 8'h04);
        wr(2'd0, 8'h00);
        rd_chk("R8 later clear", 2'd0, 8'h00);
    endtask

    task automatic t_port();
        wr(2'd0, 8'h08);
        port_in = 4'b0010; settle();
        rd_chk("R6 change sets", 2'd0, 8'h09);
        chk("R6 low prio", {irq_hi, irq_lo}, 2'b01);
        wr(2'd0, 8'h08); settle();
        rd_chk("R6 steady no refire", 2'd0, 8'h08);
        wr(2'd1, 8'h71);
        port_in = 4'b0000; settle();
        chk("R6 high prio", {irq_hi, irq_lo}, 2'b10);
        wr(2'd1, 8'h70); wr(2'd0, 8'h00);
    endtask

    task automatic t_wake();
        sleep_i = 1'b1;
        wr(2'd0, 8'h20);
        wake_cnt = 0;
        pulse_tmr(); settle();
        chk("R10 one wake pulse", wake_cnt, 1);
        chk("R9 R10 no branch w/o global", branch_req, 0);
        wr(2'd0, 8'h20);
        wake_cnt = 0;
        ext_pin[1] = 1'b1; settle();
        chk("R10 disabled source no wake", wake_cnt, 0);
        wr(2'd2, 8'h00);
        sleep_i = 1'b0;
        wake_cnt = 0;
        pulse_tmr(); settle();
        chk("R10 awake no wake", wake_cnt, 0);
        wr(2'd0, 8'h00);
        ext_pin = '0; settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edges();
        t_prio();
        t_timer();
        t_setwins();
        t_port();
        t_wake();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule